// File: doc/BRIEF.md
# Field Error-Detection CRC Inserter and Checker

This block protects a 10-bit component video word stream with two cyclic redundancy checks per field. On the transmit side it runs one CRC over every word of the field and a second one over the active-picture words only. At each field boundary it freezes both results. During the next field it writes them into a short ancillary packet on a fixed line. That line is line 9 in 525-line operation and line 5 in 625-line operation. All other words pass through with one clock of delay.

On the receive side the same two CRCs are computed over an incoming stream. The packet found on the fixed line is parsed, and the CRCs it carries are compared with the local results for the previous field. For each CRC that differs, the block gives a one-cycle error pulse and advances a saturating error counter, which can be cleared. Both paths use the same line-number, field-start, active-picture and ancillary-start timing inputs. The receive word must be aligned to that timing in the same cycle.

Top module: `edh_engine`

## Requirements
- R1: Outside the packet window, `tx_word_out` equals `tx_word_in` from exactly one clock earlier.
- R2: The packet window lasts 12 words and starts in the cycle where `anc_start` is high on the target line. The target line is 9 when `std_625` is 0 and 5 when it is 1. No other line gets a packet.
- R3: Packet words 0 to 4 are 000h, 3FFh, 3FFh, 1F4h and 206h (a data count of 6). Each appears on `tx_word_out` one clock after its window cycle.
- R4: Each CRC uses x^16+x^12+x^5+1 with a left-shifting register. Bit 0 of each word is fed first, and the register starts from zero at the word where `field_start` is high. The full CRC covers every word of the field except the 12 packet-window words. The active CRC covers only words where `active_pic` is high.
- R5: Packet words 5 to 10 are data words. The 6-bit chunk sits in bits 7:2, bit 8 is the XOR of bits 7:0, and bit 9 is the inverse of bit 8. Words 5 to 7 carry the active CRC and words 8 to 10 carry the full CRC. The chunks are bits 5:0, then bits 11:6, then bits 15:12 in chunk bits 3:0 with the valid flag in chunk bit 5.
- R6: Packet word 11 is a checksum. Its bits 8:0 are the 9-bit wrapping sum of bits 8:0 of words 3 to 10, and its bit 9 is the inverse of bit 8.
- R7: A packet carries the CRCs of the previous field. Its valid flags are 0 until two field starts have been seen since reset.
- R8: The receive path computes both CRCs with the coverage of R4. One clock after the receive checksum-word cycle, `crc_err_full` or `crc_err_active` is high for exactly one cycle when all of the following hold: the header words and the identifier matched, the received valid flag is set, the local valid flag is set, and the received and local CRC values differ.
- R9: Each error counter rises by one for each pulse of its error output and holds at 2^CNT_W-1.
- R10: `err_cnt_clr` sets both counters to zero on the next clock. If an error pulse is produced in the same cycle, that counter becomes 1 instead.
- R11: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_625 | input | 1 | 1 selects 625-line operation (packet on line 5), 0 selects 525-line operation (line 9) |
| line_num | input | LINE_W | Current line number within the field |
| field_start | input | 1 | High on the first word of a field |
| active_pic | input | 1 | High on words inside the active picture |
| anc_start | input | 1 | High on the first word of the line's ancillary space |
| tx_word_in | input | 10 | Transmit video word |
| tx_word_out | output | 10 | Transmit word with packet inserted, one clock late |
| rx_word_in | input | 10 | Receive video word, aligned to the timing inputs |
| err_cnt_clr | input | 1 | Clears both error counters |
| crc_err_full | output | 1 | Full-field CRC mismatch pulse |
| crc_err_active | output | 1 | Active-picture CRC mismatch pulse |
| err_cnt_full | output | CNT_W | Saturating full-field error count |
| err_cnt_active | output | CNT_W | Saturating active-picture error count |

## Verification
A mismatch decision and a counter clear can land in the same cycle. The bench raises `err_cnt_clr` in the receive checksum-word cycle of two fields: one whose packet reports a clean field and one whose packet follows a corrupted active word. The expected counts are 0 and 1. A behavioural model compares every output on every clock. Corruptions are placed on active and blanking words, the counters are driven into saturation, and the target line is switched between 9 and 5 partway through the run.

// File: rtl/edh_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and word-building helpers for the field CRC blocks.
// Assumes 10-bit video words and a 16-bit CRC.
package edh_pkg;
    localparam int WORD_W     = 10;
    localparam int CRC_W      = 16;
    localparam int PKT_LEN    = 12;
    localparam int IDX_W      = $clog2(PKT_LEN);
    localparam int DATA_FIRST = 5;
    localparam int DATA_WORDS = 6;
    localparam int CSUM_IDX   = PKT_LEN - 1;
    localparam int NUM_CRC    = 2;   // index 0: active picture, 1: full field
    localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;
    localparam logic [WORD_W-1:0] HDR0  = 10'h000;
    localparam logic [WORD_W-1:0] HDR12 = 10'h3FF;
    localparam logic [WORD_W-1:0] IDENT = 10'h1F4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Advances a CRC by one word, bit 0 first.
    function automatic crc_t crc_next(crc_t c, word_t w);
        crc_t r;
        logic fb;
        r = c;
        for (int b = 0; b < WORD_W; b++) begin
            fb = r[CRC_W-1] ^ w[b];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    // Wraps an 8-bit value with its parity bit and inverted parity bit.
    function automatic word_t byte_word(logic [7:0] v);
        logic p;
        p = ^v;
        return {~p, p, v};
    endfunction

    // Places a 6-bit chunk in bits 7:2 of a parity-protected word.
    function automatic word_t chunk_word(logic [5:0] c);
        return byte_word({c, 2'b00});
    endfunction
endpackage

// File: rtl/edh_pkt_window.sv
`timescale 1ns/1ps
// Finds the packet window. It opens when anc_start is high on the
// standard-dependent target line and stays open for PKT_LEN words.
// Assumes anc_start does not fire again while a window is open.
module edh_pkt_window
    import edh_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int LINE_525 = 9,
    parameter int LINE_625 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_625,
    input  logic [LINE_W-1:0] line_num,
    input  logic              anc_start,
    output logic              in_window,
    output idx_t              idx
);
    localparam idx_t LAST_IDX = idx_t'(PKT_LEN - 1);

    logic [LINE_W-1:0] target_line;
    logic              hit;
    logic              busy_q;
    idx_t              cnt_q;

    // Chooses the packet line from the selected standard.
    always_comb begin
        target_line = std_625 ? LINE_W'(LINE_625) : LINE_W'(LINE_525);
        hit         = anc_start && (line_num == target_line);
        in_window   = hit || busy_q;
        idx         = hit ? '0 : cnt_q;
    end

    // Counts the remaining words of an open window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (hit) begin
            busy_q <= 1'b1;
            cnt_q  <= idx_t'(1);
        end else if (busy_q) begin
            if (cnt_q == LAST_IDX) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + idx_t'(1);
            end
        end
    end
endmodule

// File: rtl/edh_crc_pair.sv
`timescale 1ns/1ps
// Runs the full-field and active-picture CRCs over one word stream.
// At each field start it freezes both results for the field that just
// ended. Assumes field_start marks the first word of a field and that
// packet-window words are flagged by in_window.
module edh_crc_pair
    import edh_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  field_start,
    input  logic  active_pic,
    input  logic  in_window,
    input  word_t word,
    output crc_t  lat_full,
    output crc_t  lat_active,
    output logic  lat_valid
);
    crc_t run_full_q, run_act_q;
    crc_t base_full, base_act;
    logic seen_q;

    // Selects the zero start value on the first word of a field.
    always_comb begin
        base_full = field_start ? '0 : run_full_q;
        base_act  = field_start ? '0 : run_act_q;
    end

    // Accumulates both CRCs and freezes them at the field boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_full_q <= '0;
            run_act_q  <= '0;
            lat_full   <= '0;
            lat_active <= '0;
            lat_valid  <= 1'b0;
            seen_q     <= 1'b0;
        end else begin
            run_full_q <= in_window  ? base_full : crc_next(base_full, word);
            run_act_q  <= active_pic ? crc_next(base_act, word) : base_act;
            if (field_start) begin
                lat_full   <= run_full_q;
                lat_active <= run_act_q;
                lat_valid  <= seen_q;
                seen_q     <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/edh_inserter.sv
`timescale 1ns/1ps
// Builds the 12-word packet from the frozen CRCs and puts it in place of
// the incoming words while the window is open. The output is registered.
// Assumes the frozen CRCs do not change during the window.
module edh_inserter
    import edh_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_window,
    input  idx_t  idx,
    input  word_t word_in,
    input  crc_t  lat_full,
    input  crc_t  lat_active,
    input  logic  lat_valid,
    output word_t word_out
);
    localparam int NSLOT = 1 << IDX_W;

    word_t    pw [NSLOT];
    crc_t     sel_crc [NUM_CRC];
    logic [8:0] csum;

    // Lays out the header, the data words and the checksum.
    always_comb begin
        sel_crc[0] = lat_active;
        sel_crc[1] = lat_full;
        for (int k = 0; k < NSLOT; k++) pw[k] = '0;
        pw[0] = HDR0;
        pw[1] = HDR12;
        pw[2] = HDR12;
        pw[3] = IDENT;
        pw[4] = byte_word(8'(DATA_WORDS));
        for (int g = 0; g < NUM_CRC; g++) begin
            pw[DATA_FIRST + 3*g]     = chunk_word(sel_crc[g][5:0]);
            pw[DATA_FIRST + 3*g + 1] = chunk_word(sel_crc[g][11:6]);
            pw[DATA_FIRST + 3*g + 2] = chunk_word({lat_valid, 1'b0, sel_crc[g][15:12]});
        end
        csum = '0;
        for (int k = 3; k < CSUM_IDX; k++) csum = csum + pw[k][8:0];
        pw[CSUM_IDX] = {~csum[8], csum};
    end

    // Registers either the packet word or the passed-through word.
    always_ff @(posedge clk) begin
        if (!rst_n) word_out <= '0;
        else        word_out <= in_window ? pw[idx] : word_in;
    end
endmodule

// File: rtl/edh_rx_checker.sv
`timescale 1ns/1ps
// Parses the received packet and compares the carried CRCs with the
// locally computed ones. Gives one-cycle mismatch pulses and
// saturating, clearable counters. Assumes rx words are aligned with
// the shared window timing.
module edh_rx_checker
    import edh_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_window,
    input  idx_t             idx,
    input  word_t            rx_word,
    input  crc_t             loc_full,
    input  crc_t             loc_active,
    input  logic             loc_valid,
    input  logic             cnt_clr,
    output logic [NUM_CRC-1:0] err_pulse,
    output logic [CNT_W-1:0] cnt_active,
    output logic [CNT_W-1:0] cnt_full
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [5:0]       chunk_q [DATA_WORDS];
    logic             hdr_ok_q;
    logic             at_csum;
    crc_t             loc [NUM_CRC];
    crc_t             recv [NUM_CRC];
    logic [NUM_CRC-1:0] recv_v;
    logic [NUM_CRC-1:0] mism;
    logic [CNT_W-1:0] cnt_q [NUM_CRC];

    // Tracks whether the header and the identifier matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_ok_q <= 1'b0;
        end else if (in_window) begin
            case (idx)
                idx_t'(0): hdr_ok_q <= (rx_word == HDR0);
                idx_t'(1),
                idx_t'(2): hdr_ok_q <= hdr_ok_q && (rx_word == HDR12);
                idx_t'(3): hdr_ok_q <= hdr_ok_q && (rx_word == IDENT);
                default:   hdr_ok_q <= hdr_ok_q;
            endcase
        end
    end

    // Captures the payload chunks of the six data words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DATA_WORDS; j++) chunk_q[j] <= '0;
        end else if (in_window) begin
            for (int j = 0; j < DATA_WORDS; j++)
                if (idx == idx_t'(DATA_FIRST + j)) chunk_q[j] <= rx_word[7:2];
        end
    end

    // Rebuilds the received CRCs and decides on mismatches.
    always_comb begin
        at_csum = in_window && (idx == idx_t'(CSUM_IDX));
        loc[0]  = loc_active;
        loc[1]  = loc_full;
        for (int g = 0; g < NUM_CRC; g++) begin
            recv[g]   = {chunk_q[3*g+2][3:0], chunk_q[3*g+1], chunk_q[3*g]};
            recv_v[g] = chunk_q[3*g+2][5];
            mism[g]   = at_csum && hdr_ok_q && loc_valid && recv_v[g] &&
                        (recv[g] != loc[g]);
        end
    end

    for (genvar g = 0; g < NUM_CRC; g++) begin : g_chan
        // Drives the pulse and the saturating counter of one CRC.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_pulse[g] <= 1'b0;
                cnt_q[g]     <= '0;
            end else begin
                err_pulse[g] <= mism[g];
                if (cnt_clr)
                    cnt_q[g] <= mism[g] ? CNT_W'(1) : '0;
                else if (mism[g] && cnt_q[g] != CNT_MAX)
                    cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end
        end
    end

    assign cnt_active = cnt_q[0];
    assign cnt_full   = cnt_q[1];
endmodule

// File: rtl/edh_engine.sv
`timescale 1ns/1ps
// Top level: inserts the field CRC packet on the transmit stream and
// checks the packet found on the receive stream. Both streams share the
// line, field, active and ancillary timing inputs.
module edh_engine
    import edh_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int LINE_525 = 9,
    parameter int LINE_625 = 5,
    parameter int CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_625,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_start,
    input  logic              active_pic,
    input  logic              anc_start,
    input  logic [9:0]        tx_word_in,
    output logic [9:0]        tx_word_out,
    input  logic [9:0]        rx_word_in,
    input  logic              err_cnt_clr,
    output logic              crc_err_full,
    output logic              crc_err_active,
    output logic [CNT_W-1:0]  err_cnt_full,
    output logic [CNT_W-1:0]  err_cnt_active
);
    logic   pkt_win;
    idx_t   pkt_idx;
    crc_t   tx_full, tx_act, rx_full, rx_act;
    logic   tx_valid, rx_valid;
    logic [NUM_CRC-1:0] err_pulse;

    edh_pkt_window #(.LINE_W(LINE_W), .LINE_525(LINE_525), .LINE_625(LINE_625)) u_win (
        .clk(clk), .rst_n(rst_n), .std_625(std_625), .line_num(line_num),
        .anc_start(anc_start), .in_window(pkt_win), .idx(pkt_idx)
    );

    edh_crc_pair u_tx_crc (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .active_pic(active_pic),
        .in_window(pkt_win), .word(tx_word_in),
        .lat_full(tx_full), .lat_active(tx_act), .lat_valid(tx_valid)
    );

    edh_inserter u_ins (
        .clk(clk), .rst_n(rst_n), .in_window(pkt_win), .idx(pkt_idx),
        .word_in(tx_word_in), .lat_full(tx_full), .lat_active(tx_act),
        .lat_valid(tx_valid), .word_out(tx_word_out)
    );

    edh_crc_pair u_rx_crc (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .active_pic(active_pic),
        .in_window(pkt_win), .word(rx_word_in),
        .lat_full(rx_full), .lat_active(rx_act), .lat_valid(rx_valid)
    );

    edh_rx_checker #(.CNT_W(CNT_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .in_window(pkt_win), .idx(pkt_idx),
        .rx_word(rx_word_in), .loc_full(rx_full), .loc_active(rx_act),
        .loc_valid(rx_valid), .cnt_clr(err_cnt_clr), .err_pulse(err_pulse),
        .cnt_active(err_cnt_active), .cnt_full(err_cnt_full)
    );

    assign crc_err_active = err_pulse[0];
    assign crc_err_full   = err_pulse[1];
endmodule

// File: rtl/edh_engine_sva.sv
`timescale 1ns/1ps
// Property checker for edh_engine, attached by bind below.
module edh_engine_sva #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [9:0]       tx_word_in,
    input logic [9:0]       tx_word_out,
    input logic             pkt_win,
    input logic [3:0]       pkt_idx,
    input logic             err_cnt_clr,
    input logic             crc_err_full,
    input logic             crc_err_active,
    input logic [CNT_W-1:0] err_cnt_full,
    input logic [CNT_W-1:0] err_cnt_active
);
    logic past_ok;

    // Marks cycles that have a post-reset predecessor.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_win |=> tx_word_out == $past(tx_word_in));
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_win |-> pkt_idx < 4'd12);
    assert_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_win && pkt_idx == 4'd0) |=> tx_word_out == 10'h000);
    assert_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_win && pkt_idx == 4'd3) |=> tx_word_out == 10'h1F4);
    assert_pulse_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_full |=> !crc_err_full);
    assert_pulse_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_active |=> !crc_err_active);
    assert_pulse_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (crc_err_full || crc_err_active)) |-> $past(pkt_win && pkt_idx == 4'd11));
    assert_cnt_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(err_cnt_clr)) |->
            (err_cnt_full >= $past(err_cnt_full) && err_cnt_active >= $past(err_cnt_active)));
    assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(err_cnt_clr)) |->
            (err_cnt_full <= CNT_W'(1) && err_cnt_active <= CNT_W'(1)));
endmodule

bind edh_engine edh_engine_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .tx_word_in(tx_word_in), .tx_word_out(tx_word_out),
    .pkt_win(pkt_win), .pkt_idx(pkt_idx), .err_cnt_clr(err_cnt_clr),
    .crc_err_full(crc_err_full), .crc_err_active(crc_err_active),
    .err_cnt_full(err_cnt_full), .err_cnt_active(err_cnt_active)
);

// File: tb/edh_engine_test.sv
`timescale 1ns/1ps
module edh_engine_test;
    localparam int LL = 40;      // words per line
    localparam int NL = 12;      // lines per field
    localparam int NF = 12;      // fields in the run
    localparam int CW = 2;       // counter width under test

    logic clk = 0;
    logic rst_n = 0;
    logic std_625 = 0;
    logic [9:0] line_num = '0;
    logic field_start = 0, active_pic = 0, anc_start = 0, err_cnt_clr = 0;
    logic [9:0] tx_word_in = '0, rx_word_in = '0;
    logic [9:0] tx_word_out;
    logic crc_err_full, crc_err_active;
    logic [CW-1:0] err_cnt_full, err_cnt_active;

    int checks = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    edh_engine #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .std_625(std_625), .line_num(line_num),
        .field_start(field_start), .active_pic(active_pic), .anc_start(anc_start),
        .tx_word_in(tx_word_in), .tx_word_out(tx_word_out), .rx_word_in(rx_word_in),
        .err_cnt_clr(err_cnt_clr), .crc_err_full(crc_err_full),
        .crc_err_active(crc_err_active), .err_cnt_full(err_cnt_full),
        .err_cnt_active(err_cnt_active)
    );

    // Model state
    logic [15:0] t_run_f = 0, t_run_a = 0, t_lat_f = 0, t_lat_a = 0;
    logic [15:0] r_run_f = 0, r_run_a = 0, r_lat_f = 0, r_lat_a = 0;
    logic t_seen = 0, t_val = 0, r_seen = 0, r_val = 0;
    int   cnt_f = 0, cnt_a = 0;
    logic [9:0] exp_out = 0;
    logic exp_ef = 0, exp_ea = 0;
    string out_tag = "R1";

    function automatic logic [15:0] crc_upd(logic [15:0] c, logic [9:0] w);
        for (int b = 0; b < 10; b++) begin
            logic fb;
            fb = c[15] ^ w[b];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [9:0] wrap8(logic [7:0] v);
        return {~(^v), ^v, v};
    endfunction

    function automatic logic [9:0] body_word(int k, logic [15:0] ca, logic [15:0] cf, logic v);
        logic [15:0] c;
        logic [5:0] ch;
        if (k == 3) return 10'h1F4;
        if (k == 4) return wrap8(8'd6);
        c = (k < 8) ? ca : cf;
        case ((k - 5) % 3)
            0: ch = c[5:0];
            1: ch = c[11:6];
            default: ch = {v, 1'b0, c[15:12]};
        endcase
        return wrap8({ch, 2'b00});
    endfunction

    function automatic logic [9:0] pkt_word(int k, logic [15:0] ca, logic [15:0] cf, logic v);
        int s;
        if (k == 0) return 10'h000;
        if (k == 1 || k == 2) return 10'h3FF;
        if (k < 11) return body_word(k, ca, cf, v);
        s = 0;
        for (int j = 3; j < 11; j++) s += int'(body_word(j, ca, cf, v) & 10'h1FF);
        s = s % 512;
        return {~s[8], s[8:0]};
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(out_tag, tx_word_out, exp_out);
        check("R8 full pulse", crc_err_full, exp_ef);
        check("R8 active pulse", crc_err_active, exp_ea);
        check("R9 R10 full count", err_cnt_full, cnt_f);
        check("R9 R10 active count", err_cnt_active, cnt_a);
    endtask

    // One word: drive inputs, predict outputs, advance model, compare.
    task automatic step(int f, int l, int w, int cyc);
        int target, idx;
        bit in_pkt, act, fs, corrupt, clr;
        logic [9:0] txw, good, rxw;
        bit mf, ma;
        std_625 = (f >= 6);
        target  = std_625 ? 5 : 9;
        fs      = (l == 1 && w == 0);
        act     = (l inside {6, 7, 8, 10, 11, 12}) && w >= 20 && w <= 37;
        in_pkt  = (l == target) && w >= 2 && w <= 13;
        idx     = w - 2;
        txw     = 10'((cyc * 37 + l * 5 + w * 3) & 10'h3FF);
        good    = in_pkt ? pkt_word(idx, t_lat_a, t_lat_f, t_val) : txw;
        corrupt = ((f inside {2, 5, 6, 7, 9}) && l == 7 && w == 25) ||
                  (f == 4 && l == 2 && w == 30);
        rxw     = corrupt ? (good ^ 10'h004) : good;
        clr     = (f == 9 || f == 10) && in_pkt && idx == 11;

        line_num = 10'(l); field_start = fs; active_pic = act;
        anc_start = (w == 2); tx_word_in = txw; rx_word_in = rxw; err_cnt_clr = clr;

        // Predictions for the outputs after the next edge
        exp_out = good;
        if (!in_pkt) out_tag = "R1 R2 passthrough";
        else if (idx < 5) out_tag = "R2 R3 header";
        else if (idx < 11) out_tag = "R4 R5 R7 data";
        else out_tag = "R6 checksum";
        mf = in_pkt && idx == 11 && t_val && r_val && (t_lat_f != r_lat_f);
        ma = in_pkt && idx == 11 && t_val && r_val && (t_lat_a != r_lat_a);
        exp_ef = mf; exp_ea = ma;
        if (clr) begin
            cnt_f = mf ? 1 : 0; cnt_a = ma ? 1 : 0;
        end else begin
            if (mf && cnt_f < (1 << CW) - 1) cnt_f++;
            if (ma && cnt_a < (1 << CW) - 1) cnt_a++;
        end

        // Model CRC advance
        if (fs) begin
            t_lat_f = t_run_f; t_lat_a = t_run_a; t_val = t_seen; t_seen = 1;
            r_lat_f = r_run_f; r_lat_a = r_run_a; r_val = r_seen; r_seen = 1;
            t_run_f = 0; t_run_a = 0; r_run_f = 0; r_run_a = 0;
        end
        if (!in_pkt) begin
            t_run_f = crc_upd(t_run_f, txw);
            r_run_f = crc_upd(r_run_f, rxw);
        end
        if (act) begin
            t_run_a = crc_upd(t_run_a, txw);
            r_run_a = crc_upd(r_run_a, rxw);
        end

        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        // R11: outputs while held in reset
        check("R11 reset out", tx_word_out, 0);
        check("R11 reset full pulse", crc_err_full, 0);
        check("R11 reset active pulse", crc_err_active, 0);
        check("R11 reset full count", err_cnt_full, 0);
        check("R11 reset active count", err_cnt_active, 0);
        rst_n = 1;
        cyc = 0;
        for (int f = 0; f < NF; f++)
            for (int l = 1; l <= NL; l++)
                for (int w = 0; w < LL; w++) begin
                    step(f, l, w, cyc);
                    cyc++;
                end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule